// File: doc/BRIEF.md
# Configurable PWM and Capture Timer

This block is a timer subsystem made from two 8-bit counter halves. Each half has its own clock prescaler and its own run bit. A 2-bit mode field chooses how the halves behave. In the off mode everything is frozen. In split mode the halves are two independent 8-bit PWM generators. In wide mode they are joined into one 16-bit PWM generator. In capture mode they are joined into one free-running 16-bit counter whose value is latched on input edges.

Software reaches the block through a flat, word-wide register port. Writes are single-cycle strobes. Reads are combinational. Two timer pins are driven as PWM outputs in the PWM modes. In capture mode they are released and sampled as capture inputs. The mode can be changed at any time, and the count carries on from its current value.

Top module: `pwm_cap_timer`

## Requirements
- R1: After reset, every register reads 0, `tio_out` is 0 and `tio_oe` is 0.
- R2: When mode is 00 (off), the counter and both prescalers hold their values. Writes to every register except the control register are ignored. Both pins are undriven and low.
- R3: A running half's prescaler counts clock cycles from 0 up to its programmed value P, then returns to 0. The count advances on the cycle the prescaler equals P, so it advances once every P+1 cycles.
- R4: In any mode other than off, a cleared run bit forces that half's prescaler and count to zero. In the joined modes, the lower run bit clears the whole 16-bit count.
- R5: In mode 01 (split), the low byte of each register serves the lower half and the high byte serves the upper half. The lower half uses run bit 2 and the upper half uses run bit 3, and the two halves never affect each other.
- R6: In a PWM mode, a running count advances until it equals the period, then wraps to 0. In split mode each half compares with its own period byte. In wide mode the compare is against the full 16-bit period.
- R7: In the PWM modes `tio_oe` is 11. In split mode, `tio_out[0]` is high while the lower count is below the lower duty byte, and `tio_out[1]` does the same for the upper half. In wide mode, `tio_out[0]` is high while the 16-bit count is below the duty value, and `tio_out[1]` is its complement.
- R8: In modes 10 and 11 the halves form one 16-bit count. The upper byte advances only when the lower byte wraps from 0xFF. Only run bit 2 and the lower prescaler take effect; run bit 3 has no effect.
- R9: In mode 11 (capture), `tio_oe` is 00 and the count runs freely from 0 to 0xFFFF. Each pin passes through two synchronizing flip-flops. On a rising edge of pin 0, the counter value present at the third clock edge after the pin goes high is latched into the period register. Pin 1 latches into the duty register in the same way.
- R10: If a captured value and a bus write target the same register in the same cycle, the captured value wins.
- R11: Register map by word address: 0 is control (bits 1:0 mode, bit 2 lower run, bit 3 upper run, all other bits read 0). 1 is prescale (7:0 lower, 15:8 upper). 2 is count (read only). 3 is period/capture A. 4 is duty/capture B. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| tio_in | input | 2 | Timer pins as capture inputs |
| tio_out | output | 2 | Timer pins as PWM outputs |
| tio_oe | output | 2 | Output enable for each timer pin |

## Verification
The hardest case to reach from the ports is a capture edge that arrives in the same cycle as a bus write to the capture register. Because of the synchronizer delay, the bench raises the pin and then waits exactly two falling edges. It then places the write so that the strobe is sampled on the same edge that latches the capture. A second hard case is the carry from the lower byte into the upper byte in wide mode. For this the bench runs the joined counter with no prescaling for several hundred cycles against a 16-bit period above 0xFF. A reference model in the bench follows every cycle and is compared against the outputs and the register reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_DUAL = 2'b01,
        MD_WIDE = 2'b10,
        MD_CAPT = 2'b11
    } tmr_mode_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PSC  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DUTY = 3'd4;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         clear,
    input  logic [W-1:0] match,
    output logic         tick
);

    localparam logic [W-1:0] ONE = 1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } psc_state_t;

    psc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (!hold) begin
            if (st_q.cnt == match) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise    = st_q.s2 & ~st_q.s3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_cap_timer.sv
module pwm_cap_timer
    import tmr_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_we,
    input  logic [2*HALF_W-1:0] bus_wdata,
    output logic [2*HALF_W-1:0] bus_rdata,
    input  logic [1:0]          tio_in,
    output logic [1:0]          tio_out,
    output logic [1:0]          tio_oe
);

    localparam int WW = 2 * HALF_W;
    localparam int NPIN = 2;
    localparam logic [HALF_W-1:0] ONE_H = 1;
    localparam logic [WW-1:0]     ONE_W = 1;

    typedef struct packed {
        tmr_mode_e         mode;
        logic              run_lo;
        logic              run_hi;
        logic [HALF_W-1:0] psc_lo;
        logic [HALF_W-1:0] psc_hi;
        logic [WW-1:0]     per;
        logic [WW-1:0]     duty;
        logic [WW-1:0]     cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic              off_m, wide_m;
    logic              tick_lo, tick_hi;
    logic [NPIN-1:0]   rise;
    logic [HALF_W-1:0] lo_q, hi_q, lo_n, hi_n;

    assign off_m  = (st_q.mode == MD_OFF);
    assign wide_m = st_q.mode[1];
    assign lo_q   = st_q.cnt[HALF_W-1:0];
    assign hi_q   = st_q.cnt[WW-1:HALF_W];

    tmr_prescaler #(.W(HALF_W)) u_psc_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (off_m),
        .clear (!off_m && !st_q.run_lo),
        .match (st_q.psc_lo),
        .tick  (tick_lo)
    );

    tmr_prescaler #(.W(HALF_W)) u_psc_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (off_m),
        .clear (!off_m && (wide_m || !st_q.run_hi)),
        .match (st_q.psc_hi),
        .tick  (tick_hi)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        tmr_edge_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (tio_in[g]),
            .rise  (rise[g])
        );
    end

    always_comb begin
        st_d = st_q;
        lo_n = lo_q;
        hi_n = hi_q;

        case (st_q.mode)
            MD_WIDE, MD_CAPT: begin
                if (!st_q.run_lo) begin
                    st_d.cnt = '0;
                end else if (tick_lo) begin
                    if (st_q.mode == MD_WIDE && st_q.cnt == st_q.per)
                        st_d.cnt = '0;
                    else
                        st_d.cnt = st_q.cnt + ONE_W;
                end
            end
            MD_DUAL: begin
                if (!st_q.run_lo)                        lo_n = '0;
                else if (tick_lo && lo_q == st_q.per[HALF_W-1:0]) lo_n = '0;
                else if (tick_lo)                        lo_n = lo_q + ONE_H;
                if (!st_q.run_hi)                        hi_n = '0;
                else if (tick_hi && hi_q == st_q.per[WW-1:HALF_W]) hi_n = '0;
                else if (tick_hi)                        hi_n = hi_q + ONE_H;
                st_d.cnt = {hi_n, lo_n};
            end
            default: ;
        endcase

        if (bus_we) begin
            if (bus_addr == A_CTRL) begin
                st_d.mode   = tmr_mode_e'(bus_wdata[1:0]);
                st_d.run_lo = bus_wdata[2];
                st_d.run_hi = bus_wdata[3];
            end else if (!off_m) begin
                case (bus_addr)
                    A_PSC: begin
                        st_d.psc_lo = bus_wdata[HALF_W-1:0];
                        st_d.psc_hi = bus_wdata[WW-1:HALF_W];
                    end
                    A_PER:   st_d.per  = bus_wdata;
                    A_DUTY:  st_d.duty = bus_wdata;
                    default: ;
                endcase
            end
        end

        if (st_q.mode == MD_CAPT) begin
            if (rise[0]) st_d.per  = st_q.cnt;
            if (rise[1]) st_d.duty = st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tio_out = '0;
        tio_oe  = '0;
        case (st_q.mode)
            MD_DUAL: begin
                tio_oe     = '1;
                tio_out[0] = lo_q < st_q.duty[HALF_W-1:0];
                tio_out[1] = hi_q < st_q.duty[WW-1:HALF_W];
            end
            MD_WIDE: begin
                tio_oe     = '1;
                tio_out[0] = st_q.cnt < st_q.duty;
                tio_out[1] = !(st_q.cnt < st_q.duty);
            end
            default: ;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[3:0] = {st_q.run_hi, st_q.run_lo, st_q.mode};
            A_PSC:   bus_rdata = {st_q.psc_hi, st_q.psc_lo};
            A_CNT:   bus_rdata = st_q.cnt;
            A_PER:   bus_rdata = st_q.per;
            A_DUTY:  bus_rdata = st_q.duty;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int WW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          run_lo,
    input logic [WW-1:0] cnt,
    input logic [1:0]    tio_out,
    input logic [1:0]    tio_oe
);

    localparam logic [WW-1:0] ONE_W = 1;

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> $stable(cnt));                                      // R2

    AST_OFF_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (tio_oe == 2'b00 && tio_out == 2'b00));             // R2

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !run_lo) |=> (cnt[WW/2-1:0] == '0));                  // R4

    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && run_lo) |=>
            (cnt == $past(cnt) || cnt == $past(cnt) + ONE_W || cnt == '0));     // R8

    AST_WIDE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (tio_out[1] != tio_out[0]));                        // R7

    AST_CAPT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> (tio_oe == 2'b00));                                 // R9

endmodule

bind pwm_cap_timer tmr_checker #(.WW(2*HALF_W)) u_tmr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (st_q.mode),
    .run_lo  (st_q.run_lo),
    .cnt     (st_q.cnt),
    .tio_out (tio_out),
    .tio_oe  (tio_oe)
);

// File: tb/test_pwm_cap_timer.sv
`timescale 1ns/1ps
module test_pwm_cap_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  tio_in = '0;
    logic [1:0]  tio_out, tio_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwm_cap_timer i_pwm_cap_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tio_in(tio_in),
        .tio_out(tio_out), .tio_oe(tio_oe)
    );

    // reference model state
    logic [1:0]  m_mode;
    logic        m_rlo, m_rhi;
    logic [7:0]  m_plo, m_phi, m_pclo, m_pchi;
    logic [15:0] m_per, m_duty, m_cnt;
    logic [2:0]  m_sync [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_rlo = 0; m_rhi = 0; m_plo = 0; m_phi = 0;
            m_pclo = 0; m_pchi = 0; m_per = 0; m_duty = 0; m_cnt = 0;
            m_sync[0] = 0; m_sync[1] = 0;
        end else begin
            bit off, wide, tl, th;
            logic [7:0]  lo, hi, n_pclo, n_pchi;
            logic [15:0] n_cnt, n_per, n_duty;
            logic [1:0]  n_mode;
            logic        n_rlo, n_rhi;
            logic [7:0]  n_plo, n_phi;
            off = (m_mode == 0); wide = m_mode[1];
            tl = 0; th = 0;
            n_pclo = m_pclo; n_pchi = m_pchi;
            if (!off) begin
                if (!m_rlo) n_pclo = 0;
                else if (m_pclo == m_plo) begin n_pclo = 0; tl = 1; end
                else n_pclo = m_pclo + 1;
                if (wide || !m_rhi) n_pchi = 0;
                else if (m_pchi == m_phi) begin n_pchi = 0; th = 1; end
                else n_pchi = m_pchi + 1;
            end
            n_cnt = m_cnt;
            if (wide) begin
                if (!m_rlo) n_cnt = 0;
                else if (tl) n_cnt = (m_mode == 2 && m_cnt == m_per) ? 16'h0 : m_cnt + 1;
            end else if (!off) begin
                lo = m_cnt[7:0]; hi = m_cnt[15:8];
                if (!m_rlo) lo = 0; else if (tl) lo = (lo == m_per[7:0]) ? 8'h0 : lo + 1;
                if (!m_rhi) hi = 0; else if (th) hi = (hi == m_per[15:8]) ? 8'h0 : hi + 1;
                n_cnt = {hi, lo};
            end
            n_mode = m_mode; n_rlo = m_rlo; n_rhi = m_rhi;
            n_plo = m_plo; n_phi = m_phi; n_per = m_per; n_duty = m_duty;
            if (bus_we) begin
                if (bus_addr == 0) begin
                    n_mode = bus_wdata[1:0]; n_rlo = bus_wdata[2]; n_rhi = bus_wdata[3];
                end else if (!off) begin
                    if (bus_addr == 1) begin n_plo = bus_wdata[7:0]; n_phi = bus_wdata[15:8]; end
                    if (bus_addr == 3) n_per = bus_wdata;
                    if (bus_addr == 4) n_duty = bus_wdata;
                end
            end
            if (m_mode == 3) begin
                if (m_sync[0][1] && !m_sync[0][2]) n_per = m_cnt;
                if (m_sync[1][1] && !m_sync[1][2]) n_duty = m_cnt;
            end
            for (int p = 0; p < 2; p++) m_sync[p] = {m_sync[p][1:0], tio_in[p]};
            m_mode = n_mode; m_rlo = n_rlo; m_rhi = n_rhi; m_plo = n_plo; m_phi = n_phi;
            m_pclo = n_pclo; m_pchi = n_pchi; m_per = n_per; m_duty = n_duty; m_cnt = n_cnt;
        end
    end

    function automatic logic [15:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return {12'h0, m_rhi, m_rlo, m_mode};
            3'd1: return {m_phi, m_plo};
            3'd2: return m_cnt;
            3'd3: return m_per;
            3'd4: return m_duty;
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R7 R9 R2: pins compared with the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [1:0] eo, ee;
            eo = 0; ee = 0;
            if (m_mode == 1) begin
                ee = 2'b11;
                eo[0] = m_cnt[7:0] < m_duty[7:0];
                eo[1] = m_cnt[15:8] < m_duty[15:8];
            end else if (m_mode == 2) begin
                ee = 2'b11;
                eo[0] = m_cnt < m_duty;
                eo[1] = !(m_cnt < m_duty);
            end
            check("R7/R9 pins", {12'h0, tio_oe, tio_out}, {12'h0, ee, eo});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_model(input string req, input logic [2:0] a);
        bus_addr = a; #0.5;
        check(req, bus_rdata, m_rd(a));
    endtask

    task automatic rd_lit(input string req, input logic [2:0] a, input logic [15:0] exp);
        bus_addr = a; #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_model(req, 3'd2);
        end
    endtask

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 R11: reset values
        for (int a = 0; a < 8; a++) rd_lit("R1 R11 reset", 3'(a), 16'h0);
        check("R1 pins", {14'h0, tio_oe}, 16'h0);

        // R2: writes ignored while off
        wr(3'd3, 16'h1234);
        @(negedge clk); rd_lit("R2 write ignored", 3'd3, 16'h0);

        // R5 R3 R6: split mode
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0201);
        wr(3'd3, 16'h0905);
        wr(3'd4, 16'h0402);
        rd_lit("R11 prescale", 3'd1, 16'h0201);
        wr(3'd0, 16'h000D);
        @(negedge clk); rd_lit("R11 ctrl", 3'd0, 16'h000D);
        run(80, "R3 R5 R6 split count");

        // R4: upper run cleared
        wr(3'd0, 16'h0005);
        run(10, "R5 lower independent");
        @(negedge clk); bus_addr = 3'd2; #0.5;
        check("R4 upper zero", {8'h0, bus_rdata[15:8]}, 16'h0);

        // R2: freeze
        wr(3'd0, 16'h0004);
        @(negedge clk); bus_addr = 3'd2; #0.5; held = bus_rdata;
        repeat (20) @(negedge clk);
        rd_lit("R2 count frozen", 3'd2, held);
        wr(3'd1, 16'h7777);
        @(negedge clk); rd_lit("R2 prescale write ignored", 3'd1, 16'h0201);

        // R8: wide mode, run bit 3 alone has no effect
        wr(3'd0, 16'h000A);
        run(8, "R8 upper run ignored");
        rd_lit("R8 count stays zero", 3'd2, 16'h0);
        wr(3'd1, 16'h0300);
        wr(3'd3, 16'h0120);
        wr(3'd4, 16'h0090);
        wr(3'd0, 16'h0006);
        run(700, "R6 R8 wide count carry");

        // R9: capture
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0007);
        run(40, "R9 free run");
        @(negedge clk); tio_in[0] = 1;
        run(6, "R9 capture pin0");
        rd_model("R9 period capture", 3'd3);
        @(negedge clk); tio_in[1] = 1;
        run(6, "R9 capture pin1");
        rd_model("R9 duty capture", 3'd4);
        tio_in = 0;
        run(10, "R9 free run");

        // R10: write collides with capture
        @(negedge clk); tio_in[0] = 1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1; bus_addr = 3'd3; bus_wdata = 16'hABCD;
        @(negedge clk);
        bus_we = 0;
        rd_model("R10 capture wins", 3'd3);
        bus_addr = 3'd3; #0.5;
        checks++;
        if (bus_rdata == 16'hABCD) begin
            errors++;
            $display("FAIL R10 actual=%h expected=not abcd", bus_rdata);
        end
        tio_in = 0;
        run(4, "R9 after");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule